// File: doc/BRIEF.md
# Synchronous DRAM Burst and Data-Mask Datapath

This block models the device side of a synchronous DRAM column path. It watches the command strobes on every clock edge and acts on three commands: load mode, column read and column write. When a read or write arrives, the block captures the starting column. It then steps through the burst on its own, one word per clock, without any further column commands. The burst length, the column ordering, the read latency and the write-burst policy all come from a mode word that is loaded through the address pins. A small internal word array stands in for one open row of storage.

The two directions differ in timing. A write takes its first word in the same cycle as the command. A read returns its first word CL cycles after the command. The mask pin also acts with different latencies: it blocks a write word in the cycle where it is raised, but it hides a read word two cycles after it is raised.

Read data leaves on a valid-qualified stream (`rd_valid`, `rd_data`) that has no ready input. A DRAM cannot stall its output, so there is no back-pressure: the receiver must take every word in the cycle where `rd_valid` is high. Write data is sampled in every burst cycle with no handshake, and `dqm` is the only way to withhold a word.

Top module: `sdram_burst_dp`

## Requirements
- R1: Commands are decoded only while `cs_n` is low. Load-mode is ras_n=0, cas_n=0, we_n=0. Read is ras_n=1, cas_n=0, we_n=1. Write is ras_n=1, cas_n=0, we_n=0. Every other encoding, and any cycle with `cs_n` high, changes neither the storage nor the outputs.
- R2: After reset the mode is: one-word bursts, sequential order, read latency 3, and writes that use the burst length.
- R3: The length field is `addr[2:0]`. 000 gives 1 word, 001 gives 2, 010 gives 4 and 011 gives 8. Codes 100 to 110 give 1 word. The burst stops by itself after that many words.
- R4: With `addr[3]`=0 (sequential), word k of a burst of length L that starts at column S uses column base + ((S mod L) + k) mod L, where base = S − (S mod L).
- R5: With `addr[3]`=1 (interleaved), word k uses column base + ((S mod L) XOR k).
- R6: Length code 111 selects a full-row burst. It runs sequentially across all columns, wrapping from the last column to column 0, whatever `addr[3]` is set to. It continues until the next read, write or load-mode command.
- R7: The read latency field is `addr[6:4]`. The value 2 gives latency 2, and every other value gives 3. Word k of a read issued in cycle C appears on `rd_data` with `rd_valid` high in cycle C+CL+k.
- R8: Word k of a write issued in cycle C is taken from `wr_data` in cycle C+k.
- R9: If `dqm` is high in cycle D, the read output in cycle D+2 has `rd_valid` low and `rd_data` zero.
- R10: If `dqm` is high in a cycle that carries a write word, that word is not stored, and the column keeps its old contents.
- R11: With `addr[9]`=1, every write stores exactly one word. Reads still use the programmed length.
- R12: A read or write that arrives during a burst ends that burst and starts the new one in the same cycle. A load-mode command ends the burst and performs no word in its own cycle.
- R13: When no unmasked read word is due, `rd_valid` is low and `rd_data` is zero. This holds during reset as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W (11) | Start column on read or write; mode word on load-mode |
| dqm | input | 1 | Data mask |
| wr_data | input | DATA_W (8) | Write data |
| rd_valid | output | 1 | Read word present this cycle |
| rd_data | output | DATA_W (8) | Read word; zero when `rd_valid` is low |

## Verification
The hardest case to reach is the one where several timings overlap. A mask raised for one read word may land on a word that belongs to a later burst, because a new command has cut into the first one while the earlier words are still in flight down the latency pipeline. The stimulus reaches this case by running a per-cycle reference model of the bursts. It sweeps every length, ordering and latency over every start column, with mask patterns that change with the start column. It then deliberately issues reads, writes and load-mode commands in the middle of bursts, including full-row bursts, so that in-flight read words, masks and new bursts coincide.

// File: rtl/sdram_burst_pkg.sv
`timescale 1ns/1ps
package sdram_burst_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE,
    CMD_LOADMODE,
    CMD_READ,
    CMD_WRITE
  } sd_cmd_e;

  typedef struct packed {
    logic [2:0] len_code;
    logic       interleave;
    logic       cl3;
    logic       one_write;
  } sd_mode_t;

  localparam logic [2:0] LEN_FULL = 3'b111;

  localparam sd_mode_t MODE_RESET = '{len_code: 3'b000, interleave: 1'b0,
                                      cl3: 1'b1, one_write: 1'b0};

endpackage

// File: rtl/sdram_cmd_decode.sv
`timescale 1ns/1ps
module sdram_cmd_decode
  import sdram_burst_pkg::*;
(
  input  logic    cs_n,
  input  logic    ras_n,
  input  logic    cas_n,
  input  logic    we_n,
  output sd_cmd_e cmd
);

  always_comb begin
    cmd = CMD_IDLE;
    if (!cs_n && !cas_n) begin
      if (!ras_n && !we_n) cmd = CMD_LOADMODE;
      else if (ras_n)      cmd = we_n ? CMD_READ : CMD_WRITE;
    end
  end

endmodule

// File: rtl/sdram_mode_reg.sv
`timescale 1ns/1ps
module sdram_mode_reg
  import sdram_burst_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sd_cmd_e           cmd,
  input  logic [ADDR_W-1:0] addr,
  output sd_mode_t          mode
);

  logic unused_addr_parity;
  assign unused_addr_parity = ^addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_RESET;
    end else if (cmd == CMD_LOADMODE) begin
      mode.len_code   <= addr[2:0];
      mode.interleave <= addr[3];
      mode.cl3        <= (addr[6:4] != 3'd2);
      mode.one_write  <= addr[9];
    end
  end

endmodule

// File: rtl/sdram_burst_gen.sv
`timescale 1ns/1ps
module sdram_burst_gen
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sd_cmd_e          cmd,
  input  logic [COL_W-1:0] start_col,
  input  sd_mode_t         mode,
  output logic             slot_act,
  output logic             slot_wr,
  output logic [COL_W-1:0] slot_col
);

  function automatic logic [COL_W-1:0] len_m1(input logic [2:0] code);
    case (code)
      3'b001:  return COL_W'(1);
      3'b010:  return COL_W'(3);
      3'b011:  return COL_W'(7);
      default: return '0;
    endcase
  endfunction

  function automatic logic [COL_W-1:0] col_of(input logic [COL_W-1:0] base,
                                               input logic [COL_W-1:0] step,
                                               input logic [COL_W-1:0] mask,
                                               input logic             inter);
    logic [COL_W-1:0] low;
    low = inter ? (base ^ step) : (base + step);
    return (base & ~mask) | (low & mask);
  endfunction

  logic             act_q, wr_q, full_q, inter_q;
  logic [COL_W-1:0] start_q, cnt_q, lenm1_q;
  logic             is_rw, is_wr, new_full;
  logic [COL_W-1:0] new_lenm1, run_mask;

  always_comb begin
    is_rw     = (cmd == CMD_READ) || (cmd == CMD_WRITE);
    is_wr     = (cmd == CMD_WRITE);
    new_full  = (mode.len_code == LEN_FULL) && !(is_wr && mode.one_write);
    new_lenm1 = (is_wr && mode.one_write) ? '0 : len_m1(mode.len_code);
    run_mask  = full_q ? '1 : lenm1_q;
  end

  always_comb begin
    slot_act = 1'b0;
    slot_wr  = 1'b0;
    slot_col = start_col;
    if (is_rw) begin
      slot_act = 1'b1;
      slot_wr  = is_wr;
    end else if (act_q && cmd != CMD_LOADMODE) begin
      slot_act = 1'b1;
      slot_wr  = wr_q;
      slot_col = col_of(start_q, cnt_q, run_mask, inter_q && !full_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      full_q  <= 1'b0;
      inter_q <= 1'b0;
      start_q <= '0;
      cnt_q   <= '0;
      lenm1_q <= '0;
    end else if (is_rw) begin
      act_q   <= new_full || (new_lenm1 != '0);
      wr_q    <= is_wr;
      full_q  <= new_full;
      inter_q <= mode.interleave;
      start_q <= start_col;
      cnt_q   <= COL_W'(1);
      lenm1_q <= new_lenm1;
    end else if (cmd == CMD_LOADMODE) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      cnt_q <= cnt_q + COL_W'(1);
      if (!full_q && cnt_q == lenm1_q) act_q <= 1'b0;
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WRITE && mode.one_write) |=> !act_q); // R11
  AST_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && full_q && cmd == CMD_IDLE) |=> act_q); // R6
  AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !full_q && cnt_q == lenm1_q && cmd == CMD_IDLE) |=> !act_q); // R3
  AST_MODE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LOADMODE) |=> !act_q); // R12

endmodule

// File: rtl/sdram_word_array.sv
`timescale 1ns/1ps
module sdram_word_array #(
  parameter int DATA_W = 8,
  parameter int COL_W  = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [COL_W-1:0]  col,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int WORDS = 1 << COL_W;

  logic [DATA_W-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) cells[col] <= wdata;
  end

  assign rdata = cells[col];

endmodule

// File: rtl/sdram_read_pipe.sv
`timescale 1ns/1ps
module sdram_read_pipe #(
  parameter int DATA_W = 8,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_v,
  input  logic [DATA_W-1:0] fetch_d,
  input  logic              dqm,
  input  logic              cl3,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  logic [MAX_CL:1]   v_q;
  logic [DATA_W-1:0] d_q [1:MAX_CL];
  logic [1:0]        dqm_q;
  logic [1:0]        age_q;
  logic              tap_v;
  logic [DATA_W-1:0] tap_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      dqm_q <= '0;
      age_q <= '0;
    end else begin
      v_q[1] <= fetch_v;
      for (int i = 2; i <= MAX_CL; i++) v_q[i] <= v_q[i-1];
      dqm_q <= {dqm_q[0], dqm};
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    d_q[1] <= fetch_d;
    for (int i = 2; i <= MAX_CL; i++) d_q[i] <= d_q[i-1];
  end

  generate
    if (MAX_CL >= 3) begin : g_tap
      always_comb begin
        tap_v = cl3 ? v_q[3] : v_q[2];
        tap_d = cl3 ? d_q[3] : d_q[2];
      end
    end else begin : g_tap_short
      always_comb begin
        tap_v = v_q[MAX_CL];
        tap_d = d_q[MAX_CL];
      end
    end
  endgenerate

  assign rd_valid = tap_v && !dqm_q[1];
  assign rd_data  = rd_valid ? tap_d : '0;

  AST_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && $past(dqm, 2)) |-> !rd_valid); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0)); // R13

endmodule

// File: rtl/sdram_burst_dp.sv
`timescale 1ns/1ps
module sdram_burst_dp
  import sdram_burst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COL_W  = 4,
  parameter int ADDR_W = 11,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dqm,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  sd_cmd_e           cmd;
  sd_mode_t          mode;
  logic              slot_act, slot_wr, cell_we, fetch_v;
  logic [COL_W-1:0]  slot_col;
  logic [DATA_W-1:0] cell_q;
  logic [1:0]        quiet_q;

  sdram_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  sdram_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .mode(mode)
  );

  sdram_burst_gen #(.COL_W(COL_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .start_col(addr[COL_W-1:0]),
    .mode(mode), .slot_act(slot_act), .slot_wr(slot_wr), .slot_col(slot_col)
  );

  assign cell_we = slot_act && slot_wr && !dqm;
  assign fetch_v = slot_act && !slot_wr;

  sdram_word_array #(.DATA_W(DATA_W), .COL_W(COL_W)) u_cells (
    .clk(clk), .wr_en(cell_we), .col(slot_col), .wdata(wr_data), .rdata(cell_q)
  );

  sdram_read_pipe #(.DATA_W(DATA_W), .MAX_CL(MAX_CL)) u_rpipe (
    .clk(clk), .rst_n(rst_n), .fetch_v(fetch_v), .fetch_d(cell_q),
    .dqm(dqm), .cl3(mode.cl3), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     quiet_q <= '0;
    else if (cmd == CMD_LOADMODE)   quiet_q <= '0;
    else if (quiet_q != 2'd3)       quiet_q <= quiet_q + 2'd1;
  end

  AST_LAT_CL2: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q == 2'd3 && !mode.cl3 && rd_valid) |-> $past(fetch_v, 2)); // R7
  AST_LAT_CL3: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q == 2'd3 && mode.cl3 && rd_valid) |-> $past(fetch_v, 3)); // R7
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_wr && dqm) |-> !cell_we); // R10

endmodule

// File: tb/tb_sdram_burst_dp.sv
`timescale 1ns/1ps
module tb_sdram_burst_dp;

  localparam int COLS = 16;
  localparam int RING = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [10:0] addr = '0;
  logic        dqm = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;

  always #2.5 clk = ~clk;

  sdram_burst_dp dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .dqm(dqm), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int    nvec = 0, nfail = 0, cyc = 0;
  bit    done = 0;
  string cur_req = "R13";

  bit       exp_v [RING];
  bit       msk   [RING];
  bit [7:0] exp_d [RING];
  bit [7:0] mem_m [COLS];

  int m_len = 1, m_cl = 3;
  bit m_full = 0, m_inter = 0, m_one = 0;
  int b_start = 0, b_k = 0, b_len = 1;
  bit b_act = 0, b_wr = 0, b_full = 0, b_inter = 0;

  function automatic int col_at(int s, int k, int len, bit full, bit inter);
    int base, off;
    if (full) return (s + k) % COLS;
    base = (s / len) * len;
    off  = s % len;
    return inter ? base + (off ^ k) : base + ((off + k) % len);
  endfunction

  function automatic int len_of(int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 1;
    endcase
  endfunction

  task automatic step(input bit c_cs, input bit c_ras, input bit c_cas,
                      input bit c_we, input logic [10:0] c_a, input bit c_dqm);
    int idx, col;
    bit ev, is_rd, is_wr, is_mrs;
    logic [7:0] wd, ed;
    @(negedge clk);
    idx = cyc % RING;
    ev  = exp_v[idx] && !msk[idx];
    ed  = ev ? exp_d[idx] : 8'h00;
    nvec++;
    if (rd_valid !== ev || rd_data !== ed) begin
      nfail++;
      $display("FAIL %s cycle %0d: rd_valid=%0b rd_data=%h, expected rd_valid=%0b rd_data=%h",
               cur_req, cyc, rd_valid, rd_data, ev, ed);
    end
    exp_v[idx] = 0;
    msk[idx]   = 0;
    wd = 8'(cyc * 29 + 7);
    cs_n = c_cs; ras_n = c_ras; cas_n = c_cas; we_n = c_we;
    addr = c_a; dqm = c_dqm; wr_data = wd;
    is_mrs = !c_cs && !c_ras && !c_cas && !c_we;
    is_rd  = !c_cs && c_ras && !c_cas && c_we;
    is_wr  = !c_cs && c_ras && !c_cas && !c_we;
    if (c_dqm) msk[(cyc + 2) % RING] = 1;
    if (is_rd || is_wr) begin
      b_act = 1; b_wr = is_wr; b_start = int'(c_a[3:0]); b_k = 0;
      b_inter = m_inter;
      if (is_wr && m_one) begin b_len = 1; b_full = 0; end
      else begin b_len = m_len; b_full = m_full; end
    end
    if (is_mrs) begin
      b_act   = 0;
      m_full  = (c_a[2:0] == 3'b111);
      m_len   = m_full ? COLS : len_of(int'(c_a[2:0]));
      m_inter = c_a[3];
      m_cl    = (c_a[6:4] == 3'd2) ? 2 : 3;
      m_one   = c_a[9];
    end else if (b_act) begin
      col = col_at(b_start, b_k, b_len, b_full, b_inter && !b_full);
      if (b_wr) begin
        if (!c_dqm) mem_m[col] = wd;
      end else begin
        exp_v[(cyc + m_cl) % RING] = 1;
        exp_d[(cyc + m_cl) % RING] = mem_m[col];
      end
      b_k++;
      if (!b_full && b_k == b_len) b_act = 0;
    end
    cyc++;
  endtask

  task automatic nop(input bit d = 0);
    step(0, 1, 1, 1, 11'd0, d);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) nop(0);
  endtask
  task automatic rd(input int c, input bit d = 0);
    step(0, 1, 0, 1, 11'(c), d);
  endtask
  task automatic wr(input int c, input bit d = 0);
    step(0, 1, 0, 0, 11'(c), d);
  endtask
  task automatic mrs(input int lc, input bit inter, input int clc, input bit one);
    logic [10:0] a;
    a = '0;
    a[2:0] = 3'(lc);
    a[3]   = inter;
    a[6:4] = 3'(clc);
    a[9]   = one;
    step(0, 0, 0, 0, a, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    nvec++;
    if (rd_valid !== 1'b0 || rd_data !== 8'h00) begin
      nfail++;
      $display("FAIL R13 reset: rd_valid=%0b rd_data=%h, expected rd_valid=0 rd_data=00",
               rd_valid, rd_data);
    end
    rst_n = 1'b1;

    // R2 R8: default mode is single-word writes, fill every column
    cur_req = "R2/R8 default-mode fill";
    for (int c = 0; c < COLS; c++) wr(c);
    // R2 R7: default latency 3, single-word reads
    cur_req = "R2/R7 default-mode read";
    for (int c = 0; c < COLS; c++) begin rd(c); idle(2); end
    idle(5);

    // R1: foreign encodings and deselected commands are ignored
    cur_req = "R1 ignored commands";
    step(1, 1, 0, 1, 11'd3, 0);
    step(1, 1, 0, 0, 11'd4, 0);
    step(0, 0, 1, 1, 11'd5, 0);
    step(0, 0, 1, 0, 11'd6, 0);
    step(0, 0, 0, 1, 11'd7, 0);
    step(0, 1, 1, 0, 11'd8, 0);
    step(1, 0, 0, 0, 11'h0B, 0);
    idle(4);
    for (int c = 0; c < COLS; c++) rd(c);
    idle(5);

    // R3 R4 R5 R7 R9: read sweep over length, order, latency, start column
    for (int lc = 0; lc < 4; lc++)
      for (int it = 0; it < 2; it++)
        for (int ci = 0; ci < 3; ci++) begin
          int clc;
          clc = (ci == 0) ? 2 : (ci == 1) ? 3 : 5;
          cur_req = (it != 0) ? "R5/R3/R7 interleaved read" : "R4/R3/R7 sequential read";
          mrs(lc, it[0], clc, 0);
          idle(3);
          for (int s = 0; s < COLS; s++) begin
            if (s % 2 == 1) cur_req = "R9 read mask";
            rd(s, (s % 4 == 1));
            for (int i = 0; i < 13; i++) nop((s % 2 == 1) && ((s + i) % 3 == 0));
          end
        end

    // R8 R10: write bursts with masks, then read back
    for (int lc = 0; lc < 4; lc++)
      for (int it = 0; it < 2; it++) begin
        cur_req = "R8/R10 write burst";
        mrs(lc, it[0], 2, 0);
        idle(3);
        for (int s = 0; s < COLS; s++) begin
          wr(s, (s % 2 == 1) && (s % 4 == 3));
          for (int i = 1; i < len_of(lc); i++) nop((s % 2 == 1) && (i % 3 == 0));
          idle(2);
          rd(s);
          idle(len_of(lc) + 4);
        end
      end

    // R6: full-row bursts, both order settings, ended by a mode load
    for (int it = 0; it < 2; it++) begin
      cur_req = "R6 full-row read";
      mrs(7, it[0], 2, 0);
      idle(3);
      rd(9);
      idle(21);
      mrs(7, it[0], 2, 0);
      idle(4);
      cur_req = "R6 full-row write";
      wr(3);
      idle(18);
      mrs(7, it[0], 2, 0);
      idle(4);
      rd(0);
      idle(17);
      mrs(7, it[0], 2, 0);
      idle(4);
    end

    // R11: single-word writes while reads keep their length
    cur_req = "R11 single write";
    mrs(2, 0, 3, 1);
    idle(3);
    for (int s = 0; s < COLS; s += 3) begin
      wr(s);
      idle(5);
      rd(s & ~3);
      idle(8);
    end

    // R12: bursts cut by new commands
    cur_req = "R12 interrupted bursts";
    mrs(3, 0, 2, 0);
    idle(3);
    rd(2); idle(2); rd(10); idle(3);
    wr(5); idle(2); rd(1, 1); nop(1); idle(10);
    rd(12); idle(1); wr(0); idle(3); wr(8); idle(1); rd(8); idle(12);
    rd(4); idle(3); mrs(3, 1, 2, 0); idle(5);
    wr(6); idle(2); mrs(3, 1, 2, 0); idle(3);
    for (int c = 0; c < COLS; c += 8) begin rd(c); idle(11); end
    mrs(7, 0, 3, 0); idle(3);
    rd(14); idle(6); rd(3, 1); idle(7); wr(11); idle(4); rd(11); idle(20);
    mrs(7, 0, 3, 0); idle(6);

    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: run did not complete, expected completion before timeout");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule